// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Port (Device Side)

This block is the device end of the serial port of a continuously converting sigma-delta converter. A host frames each transaction with an active-low select, clocks it with a serial clock that idles high, and sends data on a single input. Every transaction starts with an 8-bit command byte that names a register and a direction. Register contents then move over the following serial clocks. A small stub register file sits behind the port: a status byte, an interface-configuration word, the conversion result and a fixed identification word.

One output pin serves two purposes. While a read is shifting out, it carries serial data. At all other times while the port is selected, it shows whether an unread conversion is waiting, and it goes low when one is. The pin is modelled as a data value plus an output-enable. When the host deselects the port, the pin is released, but results from the converter stub continue to be captured.

The port recovers from lost framing in two ways. Raising the select line returns it to waiting for a command. A run of 64 ones sampled on the data input resets the interface and the registers. While the port is idle, serial-clock falling edges are ignored when the data input is high, so noise on the clock does not start a spurious command.

Top module: `adc_serial_port`

## Requirements
- R1: While selected and idle, a falling serial-clock edge with data-in high is ignored. A falling edge with data-in low starts a command byte that is sampled on the next 8 rising edges, MSB first. Command bit 7 must be 0, bit 6 set means read, and bits 5:0 give the register address.
- R2: Raising the select line aborts any transaction in progress, and the next byte after reselection is decoded as a fresh command.
- R3: While the select line is high, the output enable is 0. A conversion that completes while deselected is still captured and is reported as ready once the port is reselected.
- R4: While selected and no read is shifting, the pin is 0 when an unread conversion exists and 1 otherwise.
- R5: Command 0x44 reads the 24-bit result MSB first. The pin changes on falling edges, data-in is sampled on rising edges, and the first bit is valid once the eighth command rising edge has passed.
- R6: A read of the result register clears the ready indication, and the pin returns to its ready function at the last rising edge of the read.
- R7: When bit 6 of the 16-bit interface register (address 2) is set, a result read returns 32 bits: the 24-bit result followed by the status byte.
- R8: The status byte (address 0, 8 bits) has bit 7 = 1 when no unread result exists and bit 6 = 1 when the captured result is all zeros or all ones. All other bits are 0.
- R9: Sixty-four consecutive ones sampled on rising edges reset the interface to idle, clear the ready indication and return the interface register to 0x0000.
- R10: A zero sampled on data-in restarts the count of consecutive ones, so 63 ones followed by a zero do not reset anything.
- R11: The interface register is written and read back as 16 bits. The identification register (address 7) reads 16'h3C5A and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the host |
| conv_done | input | 1 | One-cycle pulse from the converter stub when a result is ready |
| conv_data | input | 24 | Result that accompanies conv_done |
| dout | output | 1 | Shared ready / serial-data pin value |
| dout_en | output | 1 | Drive enable for the shared pin, 0 means high impedance |

## Verification
The hardest condition to reach is the reset pattern, because every command begins with a zero that clears the ones count. The bench therefore sends a lone zero followed by exactly 63 ones. The zero becomes a harmless read of an unused address, while the ones keep counting underneath it. The bench then confirms that the interface register still holds its written value. A second run of ones that crosses the threshold must clear that register and the pending ready. Aborts are reached by raising the select line partway through a command, and the next transaction must then decode correctly.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_READ, ST_WRITE} st_t;
  localparam logic [5:0] ADR_STAT  = 6'd0;
  localparam logic [5:0] ADR_IFACE = 6'd2;
  localparam logic [5:0] ADR_DATA  = 6'd4;
  localparam logic [5:0] ADR_ID    = 6'd7;
  localparam int         APPEND_BIT = 6;
endpackage

// File: rtl/asp_edge.sv
module asp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/asp_resync.sv
module asp_resync #(
  parameter int ONES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rise,
  input  logic din,
  output logic fire
);
  localparam int CW = $clog2(ONES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (cs_n) begin
      cnt_d = '0;
    end else if (rise) begin
      if (!din) begin
        cnt_d = '0;
      end else if (cnt_q == CW'(ONES - 1)) begin
        cnt_d = '0;
        fire  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/asp_regs.sv
module asp_regs
  import asp_pkg::*;
#(
  parameter int          RES_W     = 24,
  parameter int          STAT_W    = 8,
  parameter int          REG_W     = 16,
  parameter logic [15:0] ID_VAL    = 16'h3C5A,
  parameter logic [15:0] IFACE_RST = 16'h0000,
  localparam int SH_W  = RES_W + STAT_W,
  localparam int LEN_W = $clog2(SH_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             rd_clr,
  input  logic             wr_en,
  input  logic [5:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [5:0]       sel_addr,
  output logic [SH_W-1:0]  sel_word,
  output logic [LEN_W-1:0] sel_len,
  output logic             rdy,
  output logic             err,
  output logic [REG_W-1:0] iface
);
  logic [REG_W-1:0]  iface_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic              rdy_d;
  logic [STAT_W-1:0] stat;

  always_comb begin
    iface_d = iface;
    if (wr_en && wr_addr == ADR_IFACE) iface_d = wr_data;
    if (resync) iface_d = REG_W'(IFACE_RST);
    res_d = conv_done ? conv_data : res_q;
    rdy_d = rdy;
    if (rd_clr)    rdy_d = 1'b0;
    if (conv_done) rdy_d = 1'b1;
    if (resync)    rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iface <= REG_W'(IFACE_RST);
      res_q <= '0;
      rdy   <= 1'b0;
    end else begin
      iface <= iface_d;
      res_q <= res_d;
      rdy   <= rdy_d;
    end
  end

  assign err = (&res_q) | ~(|res_q);

  always_comb begin
    stat = '0;
    stat[STAT_W-1] = ~rdy;
    stat[STAT_W-2] = err;
  end

  always_comb begin
    sel_word = '0;
    sel_len  = LEN_W'(8);
    case (sel_addr)
      ADR_STAT:  sel_word = {stat, {RES_W{1'b0}}};
      ADR_IFACE: begin
        sel_word = {iface, {(SH_W-REG_W){1'b0}}};
        sel_len  = LEN_W'(REG_W);
      end
      ADR_DATA: begin
        sel_word = {res_q, stat};
        sel_len  = iface[APPEND_BIT] ? LEN_W'(SH_W) : LEN_W'(RES_W);
      end
      ADR_ID: begin
        sel_word = {REG_W'(ID_VAL), {(SH_W-REG_W){1'b0}}};
        sel_len  = LEN_W'(REG_W);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import asp_pkg::*;
#(
  parameter int RES_W  = 24,
  parameter int STAT_W = 8,
  parameter int REG_W  = 16,
  parameter int ONES   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             dout,
  output logic             dout_en
);
  localparam int SH_W  = RES_W + STAT_W;
  localparam int LEN_W = $clog2(SH_W + 1);

  st_t              st, st_d;
  logic [LEN_W-1:0] cnt, cnt_d, len, len_d, sel_len;
  logic [6:0]       cmd, cmd_d;
  logic [5:0]       addr, addr_d, sel_addr;
  logic [SH_W-1:0]  sh, sh_d, sel_word;
  logic             rise, fall, resync, rd_start, rd_clr, wr_en, rdy, err;
  logic [REG_W-1:0] iface;

  asp_edge u_edge (.clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(rise), .fall(fall));

  asp_resync #(.ONES(ONES)) u_resync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .din(din), .fire(resync));

  assign sel_addr = {cmd[4:0], din};
  assign rd_clr   = rd_start && (sel_addr == ADR_DATA);

  asp_regs #(.RES_W(RES_W), .STAT_W(STAT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .resync(resync), .conv_done(conv_done),
    .conv_data(conv_data), .rd_clr(rd_clr), .wr_en(wr_en), .wr_addr(addr),
    .wr_data({sh[REG_W-2:0], din}), .sel_addr(sel_addr), .sel_word(sel_word),
    .sel_len(sel_len), .rdy(rdy), .err(err), .iface(iface));

  always_comb begin
    st_d     = st;
    cnt_d    = cnt;
    len_d    = len;
    cmd_d    = cmd;
    addr_d   = addr;
    sh_d     = sh;
    rd_start = 1'b0;
    wr_en    = 1'b0;
    if (cs_n || resync) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      case (st)
        ST_IDLE: if (fall && !din) begin
          st_d  = ST_CMD;
          cnt_d = '0;
        end
        ST_CMD: if (rise) begin
          cmd_d = {cmd[5:0], din};
          cnt_d = cnt + 1'b1;
          if (cnt == LEN_W'(7)) begin
            cnt_d  = '0;
            addr_d = sel_addr;
            len_d  = sel_len;
            if (cmd[6]) begin
              st_d = ST_IDLE;
            end else if (cmd[5]) begin
              rd_start = 1'b1;
              sh_d     = sel_word;
              st_d     = ST_READ;
            end else begin
              st_d = ST_WRITE;
            end
          end
        end
        ST_READ: begin
          if (fall && cnt != '0) sh_d = {sh[SH_W-2:0], 1'b0};
          if (rise) begin
            cnt_d = cnt + 1'b1;
            if (cnt == len - 1'b1) begin
              st_d  = ST_IDLE;
              cnt_d = '0;
            end
          end
        end
        ST_WRITE: if (rise) begin
          sh_d  = {sh[SH_W-2:0], din};
          cnt_d = cnt + 1'b1;
          if (cnt == len - 1'b1) begin
            wr_en = 1'b1;
            st_d  = ST_IDLE;
            cnt_d = '0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      len     <= '0;
      cmd     <= '0;
      addr    <= '0;
      sh      <= '0;
      dout_en <= 1'b0;
    end else begin
      st      <= st_d;
      cnt     <= cnt_d;
      len     <= len_d;
      cmd     <= cmd_d;
      addr    <= addr_d;
      sh      <= sh_d;
      dout_en <= ~cs_n;
    end
  end

  assign dout = (st == ST_READ) ? sh[SH_W-1] : ~rdy;
endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
  parameter int RES_W = 24,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             conv_done,
  input logic [RES_W-1:0] conv_data,
  input logic             dout_en,
  input logic [1:0]       st,
  input logic             rdy,
  input logic             err,
  input logic             resync,
  input logic             rd_clr,
  input logic [REG_W-1:0] iface
);
  // R2
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st == 2'd0));

  // R3
  release_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !dout_en);

  // R4
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !resync) |=> rdy);

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !conv_done && !resync) |=> !rdy);

  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (conv_data == '0)) |=> err);

  // R9
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (st == 2'd0 && !rdy && iface == '0));
endmodule

bind adc_serial_port asp_checker #(.RES_W(RES_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .conv_done(conv_done),
  .conv_data(conv_data), .dout_en(dout_en), .st(st), .rdy(rdy), .err(err),
  .resync(resync), .rd_clr(rd_clr), .iface(iface));

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
  logic        clk, rst_n, cs_n, sclk, din, conv_done;
  logic [23:0] conv_data;
  logic        dout, dout_en;
  int          n_run, n_fail;

  adc_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_done(conv_done), .conv_data(conv_data), .dout(dout), .dout_en(dout_en));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0; din = tx[i]; wt(4);
      rx[i] = dout;
      sclk = 1'b1; wt(4);
    end
    din = 1'b1;
  endtask

  task automatic rd(input logic [7:0] c, input int n, output logic [31:0] rx);
    logic [31:0] junk;
    xfer({24'h0, c}, 8, junk);
    xfer(32'hFFFF_FFFF, n, rx);
  endtask

  task automatic wr(input logic [7:0] c, input logic [15:0] v);
    logic [31:0] junk;
    xfer({24'h0, c}, 8, junk);
    xfer({16'h0, v}, 16, junk);
  endtask

  task automatic conv(input logic [23:0] v);
    conv_data = v; conv_done = 1'b1; wt(1);
    conv_done = 1'b0; wt(2);
  endtask

  task automatic sel(input logic low);
    cs_n = !low; wt(4);
  endtask

  task automatic t_reset_state;
    chk("R3 reset dout_en", {31'b0, dout_en}, 32'h0);
    sel(1);
    chk("R3 enable when selected", {31'b0, dout_en}, 32'h1);
    chk("R4 pin high no data", {31'b0, dout}, 32'h1);
  endtask

  task automatic t_ready_and_read;
    logic [31:0] rx;
    conv(24'hA5_3C_81);
    chk("R4 pin low when ready", {31'b0, dout}, 32'h0);
    rd(8'h44, 24, rx);
    chk("R5 data read", rx, 32'h00A5_3C81);
    wt(2);
    chk("R6 pin back to ready, cleared", {31'b0, dout}, 32'h1);
  endtask

  task automatic t_idle_edges;
    logic [31:0] rx;
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; din = 1'b1; wt(4); sclk = 1'b1; wt(4);
    end
    rd(8'h47, 16, rx);
    chk("R1 ignored edges then ID read", rx, 32'h0000_3C5A);
  endtask

  task automatic t_regs;
    logic [31:0] rx;
    wr(8'h02, 16'h1234);
    rd(8'h42, 16, rx);
    chk("R11 iface readback", rx, 32'h0000_1234);
    wr(8'h07, 16'h0000);
    rd(8'h47, 16, rx);
    chk("R11 ID write ignored", rx, 32'h0000_3C5A);
  endtask

  task automatic t_cs_high_conv;
    sel(0);
    chk("R3 released while deselected", {31'b0, dout_en}, 32'h0);
    conv(24'h12_34_56);
    sel(1);
    chk("R3 captured while deselected", {31'b0, dout}, 32'h0);
  endtask

  task automatic t_abort;
    logic [31:0] rx;
    xfer(32'h4, 4, rx);
    sel(0);
    chk("R2 released on abort", {31'b0, dout_en}, 32'h0);
    sel(1);
    rd(8'h47, 16, rx);
    chk("R2 fresh command after abort", rx, 32'h0000_3C5A);
  endtask

  task automatic t_append_status;
    logic [31:0] rx;
    wr(8'h02, 16'h0040);
    conv(24'hFF_FF_FF);
    rd(8'h44, 32, rx);
    chk("R7 appended read", rx, 32'hFFFF_FF40);
    rd(8'h40, 8, rx);
    chk("R8 status after read", rx, 32'h0000_00C0);
    conv(24'h00_10_00);
    rd(8'h40, 8, rx);
    chk("R8 status unread no error", rx, 32'h0000_0000);
  endtask

  task automatic t_ones;
    logic [31:0] rx;
    xfer(32'h0, 1, rx);
    for (int i = 0; i < 63; i++) xfer(32'h1, 1, rx);
    rd(8'h42, 16, rx);
    chk("R10 63 ones no reset", rx, 32'h0000_0040);
    conv(24'h55_55_55);
    chk("R9 ready before pattern", {31'b0, dout}, 32'h0);
    for (int i = 0; i < 64; i++) xfer(32'h1, 1, rx);
    wt(2);
    chk("R9 ready cleared", {31'b0, dout}, 32'h1);
    rd(8'h42, 16, rx);
    chk("R9 iface defaulted", rx, 32'h0000_0000);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b1;
    conv_done = 1'b0; conv_data = '0;
    wt(5);
    rst_n = 1'b1;
    wt(3);
    t_reset_state;
    t_ready_and_read;
    t_idle_edges;
    t_regs;
    t_cs_high_conv;
    t_abort;
    t_append_status;
    t_ones;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule